// File: doc/BRIEF.md
# Two-Bank Synchronous Graphics DRAM Command Front End

This block sits on the device side of a two-bank synchronous graphics DRAM. On every rising clock edge it samples the active-low command pins (chip select, row strobe, column strobe, write enable), the clock-enable pin and an 11-bit address bus. From these it decodes one command. It keeps the row address opened in each bank, the last column address and the last selected bank. It also tracks whether each bank is idle or active.

Clock enable controls the clocking state. A low sample stops command processing from the following edge onward. If both banks are idle at that moment, the block enters power-down instead of plain suspend. A high sample restarts processing on that same edge.

The outputs are a one-cycle decoded-command strobe with a command code, the latched addresses, the bank states and a sticky protocol-error flag. A later array model or protocol checker uses them. All outputs are registered, so a command sampled on one edge is visible right after that edge.

Top module: `sgr_cmd_front`

## Requirements
- R1: A synchronous active-high reset clears the strobe, the command code, all bank states, all row registers, the column register, the bank register, the error flag and both clock-state flags.
- R2: While chip select is high, no command is decoded: there is no strobe and no latched state changes.
- R3: With chip select low, the value {ras_n,cas_n,we_n} selects the command as follows. 011 is activate (code 1). 101 is read (code 2). 100 is write (code 3). 010 is precharge (code 4). 001 is auto refresh (code 5). 000 is mode set (code 6). The values 111 and 110 are no operation. An accepted command other than no operation raises cmd_valid_o for one cycle after its edge, with its code on cmd_code_o. Otherwise cmd_code_o is 0.
- R4: An activate to an idle bank copies addr[9:0] into that bank's row register and marks the bank active. Bank 0 is the low row field.
- R5: A read or write to an active bank copies addr[7:0] into the column register.
- R6: addr[10] selects the bank (0 or 1). It is stored in the bank register on activate, read, write, precharge and mode set. Auto refresh leaves the bank register unchanged.
- R7: A precharge returns the selected bank to idle and leaves the other bank unchanged.
- R8: An activate to an active bank, or a read or write to an idle bank, sets a sticky error flag that only reset clears. Such a command is still strobed but changes no row, column or bank-state register.
- R9: When clock enable is sampled low in the running state, the command on that edge is still accepted. From the next edge onward, commands are ignored (no strobe, no state change) while clock enable stays low. If a bank was active before that edge, the suspend flag is raised.
- R10: If both banks were idle before the edge on which clock enable is first sampled low, the power-down flag is raised instead of the suspend flag.
- R11: When clock enable is sampled high, the command on that same edge is accepted and both clock-state flags clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| cke_i | input | 1 | Clock enable |
| cs_n_i | input | 1 | Chip select, active low |
| ras_n_i | input | 1 | Row strobe, active low |
| cas_n_i | input | 1 | Column strobe, active low |
| we_n_i | input | 1 | Write enable, active low |
| addr_i | input | 11 | Address; bit 10 selects the bank |
| cmd_valid_o | output | 1 | One-cycle strobe for an accepted command |
| cmd_code_o | output | 3 | Code of the command being strobed |
| cmd_bank_o | output | 1 | Last latched bank select |
| row_addr_o | output | 20 | Row registers, bank 0 in bits 9:0 |
| col_addr_o | output | 8 | Last latched column address |
| bank_active_o | output | 2 | Active flag per bank |
| proto_err_o | output | 1 | Sticky protocol-error flag |
| suspended_o | output | 1 | Clock suspended with a bank active |
| power_down_o | output | 1 | Power-down with both banks idle |

## Verification
A wrong bank state does not always show up at once. It appears on the next command that consults it: an activate or access sets the error flag one cycle later, and a low clock-enable sample picks suspend instead of power-down. The bench therefore brings each of the four bank-state patterns through every command encoding on both banks. A wrong clock-state decision shows within one cycle as an unexpected strobe or a missing one. All 64 six-cycle clock-enable sequences are driven from every bank pattern, and every output is compared after every edge.

// File: rtl/sgr_cmd_pkg.sv
package sgr_cmd_pkg;

  typedef enum logic [2:0] {
    CMD_NONE = 3'd0,
    CMD_ACT  = 3'd1,
    CMD_RD   = 3'd2,
    CMD_WR   = 3'd3,
    CMD_PRE  = 3'd4,
    CMD_REF  = 3'd5,
    CMD_MRS  = 3'd6
  } sgr_cmd_e;

  typedef enum logic [1:0] {
    PM_RUN  = 2'd0,
    PM_SUSP = 2'd1,
    PM_PDN  = 2'd2
  } sgr_pm_e;

  function automatic logic cmd_is_banked(sgr_cmd_e c);
    return (c == CMD_ACT) || (c == CMD_RD) || (c == CMD_WR) ||
           (c == CMD_PRE) || (c == CMD_MRS);
  endfunction

  function automatic logic cmd_is_access(sgr_cmd_e c);
    return (c == CMD_RD) || (c == CMD_WR);
  endfunction

endpackage

// File: rtl/sgr_cmd_decode.sv
module sgr_cmd_decode
  import sgr_cmd_pkg::*;
(
  input  logic     cs_n,
  input  logic     ras_n,
  input  logic     cas_n,
  input  logic     we_n,
  output sgr_cmd_e cmd
);

  always_comb begin
    cmd = CMD_NONE;
    if (!cs_n) begin
      unique case ({ras_n, cas_n, we_n})
        3'b011:  cmd = CMD_ACT;
        3'b101:  cmd = CMD_RD;
        3'b100:  cmd = CMD_WR;
        3'b010:  cmd = CMD_PRE;
        3'b001:  cmd = CMD_REF;
        3'b000:  cmd = CMD_MRS;
        default: cmd = CMD_NONE;
      endcase
    end
  end

endmodule

// File: rtl/sgr_cke_ctrl.sv
module sgr_cke_ctrl
  import sgr_cmd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic cke,
  input  logic all_idle,
  output logic accept,
  output logic suspended,
  output logic power_down
);

  sgr_pm_e mode_q;

  // The edge that first samples CKE low still runs; sleep begins after it.
  assign accept     = cke || (mode_q == PM_RUN);
  assign suspended  = (mode_q == PM_SUSP);
  assign power_down = (mode_q == PM_PDN);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= PM_RUN;
    end else if (cke) begin
      mode_q <= PM_RUN;
    end else if (mode_q == PM_RUN) begin
      mode_q <= all_idle ? PM_PDN : PM_SUSP;
    end
  end

  AST_PDN_FROM_IDLE: assert property (@(posedge clk) disable iff (rst)
    (power_down && !$past(power_down)) |-> $past(all_idle)); // R10

  AST_WAKE_SAME_EDGE: assert property (@(posedge clk) disable iff (rst)
    cke |=> (!suspended && !power_down)); // R11

endmodule

// File: rtl/sgr_bank_slot.sv
module sgr_bank_slot #(
  parameter int ROW_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             act_hit,
  input  logic             pre_hit,
  input  logic [ROW_W-1:0] row_in,
  output logic             active,
  output logic [ROW_W-1:0] row
);

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      row    <= '0;
    end else if (act_hit && !active) begin
      active <= 1'b1;
      row    <= row_in;
    end else if (pre_hit) begin
      active <= 1'b0;
    end
  end

  AST_ACT_OPENS: assert property (@(posedge clk) disable iff (rst)
    act_hit |=> active); // R4

  AST_PRE_CLOSES: assert property (@(posedge clk) disable iff (rst)
    pre_hit |=> !active); // R7

  AST_ROW_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(act_hit && !active) |=> $stable(row)); // R8

endmodule

// File: rtl/sgr_cmd_front.sv
module sgr_cmd_front
  import sgr_cmd_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int ROW_W     = 10,
  parameter int COL_W     = 8,
  parameter int BANK_BIT  = 10,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int ADDR_W   = BANK_BIT + BANK_W
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cke_i,
  input  logic                       cs_n_i,
  input  logic                       ras_n_i,
  input  logic                       cas_n_i,
  input  logic                       we_n_i,
  input  logic [ADDR_W-1:0]          addr_i,
  output logic                       cmd_valid_o,
  output logic [2:0]                 cmd_code_o,
  output logic [BANK_W-1:0]          cmd_bank_o,
  output logic [NUM_BANKS*ROW_W-1:0] row_addr_o,
  output logic [COL_W-1:0]           col_addr_o,
  output logic [NUM_BANKS-1:0]       bank_active_o,
  output logic                       proto_err_o,
  output logic                       suspended_o,
  output logic                       power_down_o
);

  sgr_cmd_e          cmd_raw;
  sgr_cmd_e          cmd_acc;
  logic              accept;
  logic              all_idle;
  logic [BANK_W-1:0] sel_bank;
  logic              sel_active;
  logic              err_now;

  sgr_cmd_decode u_decode (
    .cs_n  (cs_n_i),
    .ras_n (ras_n_i),
    .cas_n (cas_n_i),
    .we_n  (we_n_i),
    .cmd   (cmd_raw)
  );

  assign all_idle = ~|bank_active_o;

  sgr_cke_ctrl u_cke (
    .clk        (clk),
    .rst        (rst),
    .cke        (cke_i),
    .all_idle   (all_idle),
    .accept     (accept),
    .suspended  (suspended_o),
    .power_down (power_down_o)
  );

  assign cmd_acc    = accept ? cmd_raw : CMD_NONE;
  assign sel_bank   = addr_i[BANK_BIT +: BANK_W];
  assign sel_active = bank_active_o[sel_bank];
  assign err_now    = ((cmd_acc == CMD_ACT) && sel_active) ||
                      (cmd_is_access(cmd_acc) && !sel_active);

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic act_hit;
    logic pre_hit;
    assign act_hit = (cmd_acc == CMD_ACT) && (sel_bank == BANK_W'(g));
    assign pre_hit = (cmd_acc == CMD_PRE) && (sel_bank == BANK_W'(g));

    sgr_bank_slot #(.ROW_W(ROW_W)) u_slot (
      .clk     (clk),
      .rst     (rst),
      .act_hit (act_hit),
      .pre_hit (pre_hit),
      .row_in  (addr_i[ROW_W-1:0]),
      .active  (bank_active_o[g]),
      .row     (row_addr_o[g*ROW_W +: ROW_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_valid_o <= 1'b0;
      cmd_code_o  <= 3'd0;
      cmd_bank_o  <= '0;
      col_addr_o  <= '0;
      proto_err_o <= 1'b0;
    end else begin
      cmd_valid_o <= (cmd_acc != CMD_NONE);
      cmd_code_o  <= cmd_acc;
      if (cmd_is_banked(cmd_acc) && !err_now) begin
        cmd_bank_o <= sel_bank;
      end
      if (cmd_is_access(cmd_acc) && sel_active) begin
        col_addr_o <= addr_i[COL_W-1:0];
      end
      if (err_now) begin
        proto_err_o <= 1'b1;
      end
    end
  end

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    proto_err_o |=> proto_err_o); // R8

  AST_QUIET_ASLEEP: assert property (@(posedge clk) disable iff (rst)
    (!cke_i && (suspended_o || power_down_o)) |=> !cmd_valid_o); // R9

  AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (rst)
    cs_n_i |=> !cmd_valid_o); // R2

endmodule

// File: tb/sgr_cmd_front_tb.sv
module sgr_cmd_front_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cke = 1'b1;
  logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [10:0] addr = '0;
  logic        cmd_valid;
  logic [2:0]  cmd_code;
  logic [0:0]  cmd_bank;
  logic [19:0] row_addr;
  logic [7:0]  col_addr;
  logic [1:0]  bank_active;
  logic        proto_err, suspended, power_down;

  sgr_cmd_front dut_i (
    .clk(clk), .rst(rst), .cke_i(cke), .cs_n_i(cs_n), .ras_n_i(ras_n),
    .cas_n_i(cas_n), .we_n_i(we_n), .addr_i(addr),
    .cmd_valid_o(cmd_valid), .cmd_code_o(cmd_code), .cmd_bank_o(cmd_bank),
    .row_addr_o(row_addr), .col_addr_o(col_addr), .bank_active_o(bank_active),
    .proto_err_o(proto_err), .suspended_o(suspended), .power_down_o(power_down)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Expected state, built from the requirements
  logic       m_act [2];
  logic [9:0] m_row [2];
  logic [7:0] m_col;
  logic       m_bank;
  logic       m_err;
  int         m_mode; // 0 run, 1 suspend, 2 power-down
  logic       m_valid;
  int         m_code;

  task automatic check_val(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic check_all();
    check_val("R3 strobe", int'(cmd_valid), int'(m_valid));
    check_val("R3 code", int'(cmd_code), m_code);
    check_val("R4 row bank0", int'(row_addr[9:0]), int'(m_row[0]));
    check_val("R4 row bank1", int'(row_addr[19:10]), int'(m_row[1]));
    check_val("R5 column", int'(col_addr), int'(m_col));
    check_val("R6 bank", int'(cmd_bank), int'(m_bank));
    check_val("R7 bank0 state", int'(bank_active[0]), int'(m_act[0]));
    check_val("R7 bank1 state", int'(bank_active[1]), int'(m_act[1]));
    check_val("R8 error", int'(proto_err), int'(m_err));
    check_val("R9 suspend", int'(suspended), int'(m_mode == 1));
    check_val("R10 power-down", int'(power_down), int'(m_mode == 2));
  endtask

  task automatic model_update();
    bit acc;
    bit idle;
    int code;
    int b;
    acc  = cke || (m_mode == 0);
    idle = !m_act[0] && !m_act[1];
    code = 0;
    if (!cs_n) begin
      case ({ras_n, cas_n, we_n})
        3'b011: code = 1;
        3'b101: code = 2;
        3'b100: code = 3;
        3'b010: code = 4;
        3'b001: code = 5;
        3'b000: code = 6;
        default: code = 0;
      endcase
    end
    if (!acc) code = 0;
    b = int'(addr[10]);
    m_valid = (code != 0);
    m_code  = code;
    case (code)
      1: if (m_act[b]) m_err = 1'b1;
         else begin m_act[b] = 1'b1; m_row[b] = addr[9:0]; m_bank = addr[10]; end
      2, 3: if (!m_act[b]) m_err = 1'b1;
            else begin m_col = addr[7:0]; m_bank = addr[10]; end
      4: begin m_act[b] = 1'b0; m_bank = addr[10]; end
      6: m_bank = addr[10];
      default: ;
    endcase
    if (cke) m_mode = 0;
    else if (m_mode == 0) m_mode = idle ? 2 : 1;
  endtask

  // Entered and left at a falling edge
  task automatic step(bit k, bit cs, logic [2:0] rcw, logic [10:0] a);
    int prev_mode;
    bit prev_cs;
    prev_mode = m_mode;
    prev_cs = cs;
    cke = k; cs_n = cs; {ras_n, cas_n, we_n} = rcw; addr = a;
    @(posedge clk);
    model_update();
    @(negedge clk);
    check_all();
    if (prev_cs) check_val("R2 deselect strobe", int'(cmd_valid), 0);
    if (k && prev_mode != 0) check_val("R11 wake strobe", int'(cmd_valid), int'(m_valid));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; cke = 1'b1; cs_n = 1'b1; {ras_n, cas_n, we_n} = 3'b111; addr = '0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    m_act[0] = 0; m_act[1] = 0; m_row[0] = '0; m_row[1] = '0;
    m_col = '0; m_bank = 0; m_err = 0; m_mode = 0; m_valid = 0; m_code = 0;
  endtask

  task automatic open_banks(int s);
    for (int i = 0; i < 2; i++)
      if (s[i]) step(1'b1, 1'b0, 3'b011, {i[0], 10'(37 * (s + 3 * i) + 5)});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1: state right after reset
    check_all();
    check_val("R1 reset strobe", int'(cmd_valid), 0);
    check_val("R1 reset banks", int'(bank_active), 0);

    // Every encoding on both banks from every bank pattern
    for (int s = 0; s < 4; s++)
      for (int enc = 0; enc < 16; enc++)
        for (int b = 0; b < 2; b++) begin
          do_reset();
          open_banks(s);
          step(1'b1, enc[3], enc[2:0], {b[0], 10'(enc * 59 + s * 131 + b * 7)});
          step(1'b1, 1'b1, 3'b111, 11'h0);
        end

    // Every six-cycle clock-enable sequence from every bank pattern
    for (int s = 0; s < 4; s++)
      for (int pat = 0; pat < 64; pat++) begin
        do_reset();
        open_banks(s);
        for (int i = 0; i < 6; i++) begin
          int e;
          e = (pat * 7 + i * 3 + s) & 15;
          step(pat[i], e[3], e[2:0], {e[0] ^ pat[0], 10'(pat * 13 + i * 97)});
        end
        step(1'b1, 1'b1, 3'b111, 11'h0);
      end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule